// File: doc/BRIEF.md
# Host Control Port Decoder with Input-Ready Latch

This block sits on the host I/O bus of a display board and owns a sixteen-port window of the 16-bit I/O address space. It recognises the window from a switch-set base, turns the low nibble into a relative port number, and holds the small set of board-level control registers that live there. These are a bank-enable register, a relocation register that moves the window and the memory window between two standard address sets, a keyboard-clock hold bit, and an input-ready latch. The latch captures keyboard bytes and light-pen strobes and drives the interrupt request.

Several boards can share one base address. The bank-enable register is always reachable, and each board takes its enable from a jumper-chosen bit of the written byte. A disabled board answers nothing but that register, and its memory-access enable output is low. The other relative ports are passed on as one-hot port enables to the registers that sit outside this block.

The input-ready latch is a four-state machine. RS_EMPTY is the idle state. RS_KEY is entered from RS_EMPTY when a keyboard byte completes. RS_PEN is entered from RS_EMPTY on a light-pen rising edge, and a keyboard byte takes priority if both arrive in the same cycle. RS_HOST is entered from any state when the host writes the load port. Writing the acknowledge port returns every state to RS_EMPTY, and that write has priority over all other transitions.

Top module: `ctl_port_decoder`

## Requirements
- R1: An access hits the window only when address bits 15..12 are zero and bits 11..4 equal the effective base; bits 3..0 give the relative port.
- R2: A write to relative port 0 sets the bank enable to the data bit chosen by `bank_bit_sel`. Port 0 is decoded whether or not the board is enabled, and reset sets the enable to 1.
- R3: While the bank enable is 0, every port other than 0 is ignored: no port enable, no read response and no register change. `mem_access_en` is 0 in this state and 1 otherwise.
- R4: A write to relative port 1 stores data bit 0 as the relocation bit, and reset clears it. The effective relocation is the stored bit AND NOT `flip_disable`. When it is 1, the compare for address bits 5 and 6 is inverted and `mem_a15_flip` is 1.
- R5: A read of relative port 10 returns {4'b0000, vsync, pen_sw, ready, disp_en}, with bit 3 as vsync and bit 0 as disp_en.
- R6: A write to relative port 11 clears the ready flag, zeroes the input data register and stores data bit 7 in `kbd_clk_pull`, which resets to 0.
- R7: A write to relative port 12 sets the ready flag. A read of port 12 returns the input data register.
- R8: When the flag is clear, `kbd_strobe` loads `kbd_byte` into the data register and sets the flag. A rising edge of `pen_in` sets the flag without changing the data register. `irq` equals the flag.
- R9: While the flag is set, keyboard bytes and pen edges have no effect until port 11 is written. Port writes take priority over these events in the same cycle.
- R10: Reads of relative ports other than 10 and 12 return 8'hFF, and writes to ports 2 to 10 and 13 to 15 change nothing here. `rd_valid` is 1 only during a decoded read, and `rd_data` is 0 when `rd_valid` is 0.
- R11: `port_en` is one-hot at the decoded relative port during any accepted read or write, and all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| base_sel | input | 8 | Switch-set base for address bits 11..4 |
| bank_bit_sel | input | 3 | Jumper: data bit used as this board's enable |
| flip_disable | input | 1 | Jumper: forces relocation off |
| kbd_byte | input | 8 | Completed keyboard byte |
| kbd_strobe | input | 1 | One-cycle pulse: kbd_byte is complete |
| pen_in | input | 1 | Light-pen trigger, rising edge active |
| pen_sw | input | 1 | Raw pen switch level |
| vsync | input | 1 | Raw vertical sync status |
| disp_en | input | 1 | Raw display-enabled status |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data is driven this cycle |
| port_en | output | 16 | One-hot enable of the decoded relative port |
| mem_access_en | output | 1 | Board enabled for memory accesses |
| mem_a15_flip | output | 1 | Invert memory address bit 15 compare |
| irq | output | 1 | Interrupt request |
| kbd_clk_pull | output | 1 | Pull-down drive for the keyboard clock line |

## Verification
The hardest states to reach are those where one register changes which addresses the block answers. After relocation, the old addresses must fall silent and the inverted ones must respond. After the bank is disabled, only port 0 can bring the board back. The stimulus computes each access address from the model's current relocation state, and it also sends deliberate accesses to the stale address set and to a disabled board. A keyboard byte and a pen edge are injected while the flag is already held, so the dropped events can be seen through the port 12 read-back.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    typedef enum logic [1:0] {
        RS_EMPTY = 2'd0,
        RS_KEY   = 2'd1,
        RS_PEN   = 2'd2,
        RS_HOST  = 2'd3
    } rdy_state_e;

    localparam logic [3:0] P_BANK   = 4'd0;
    localparam logic [3:0] P_FLIP   = 4'd1;
    localparam logic [3:0] P_STATUS = 4'd10;
    localparam logic [3:0] P_ACK    = 4'd11;
    localparam logic [3:0] P_LOAD   = 4'd12;
endpackage

// File: rtl/cpd_decode.sv
module cpd_decode #(
    parameter int ADDR_W = 16,
    parameter int REL_W  = 4,
    parameter int TOP_W  = 4,
    parameter int FLIP_A = 5,
    parameter int FLIP_B = 6,
    localparam int BASE_W = ADDR_W - TOP_W - REL_W,
    localparam int NPORT  = 1 << REL_W
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BASE_W-1:0] base_sel,
    input  logic              flip_eff,
    input  logic              bank_en,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [REL_W-1:0]  rel,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic [NPORT-1:0]  port_en
);
    logic [BASE_W-1:0] exp_base;
    logic              top_zero;
    logic              hit;
    logic              allowed;

    for (genvar g = 0; g < BASE_W; g++) begin : g_cmp
        if ((g + REL_W == FLIP_A) || (g + REL_W == FLIP_B)) begin : g_flip
            assign exp_base[g] = base_sel[g] ^ flip_eff;
        end else begin : g_plain
            assign exp_base[g] = base_sel[g];
        end
    end

    assign top_zero = (io_addr[ADDR_W-1 -: TOP_W] == '0);
    assign hit      = top_zero && (io_addr[REL_W +: BASE_W] == exp_base);
    assign rel      = io_addr[REL_W-1:0];
    assign allowed  = hit && (bank_en || (rel == '0));
    assign rd_ok    = allowed && io_rd;
    assign wr_ok    = allowed && io_wr;

    always_comb begin
        port_en = '0;
        if (rd_ok || wr_ok) begin
            port_en = NPORT'(1) << rel;
        end
    end

    always_comb begin
        a_r11_onehot: assert ($onehot0(port_en));
    end
endmodule

// File: rtl/cpd_regs.sv
module cpd_regs #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_bank,
    input  logic              wr_flip,
    input  logic              wr_ack,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  bank_bit_sel,
    input  logic              flip_disable,
    output logic              bank_en,
    output logic              flip_eff,
    output logic              kclk_pull
);
    logic flip_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_en   <= 1'b1;
            flip_q    <= 1'b0;
            kclk_pull <= 1'b0;
        end else begin
            if (wr_bank) begin
                bank_en <= wdata[bank_bit_sel];
            end
            if (wr_flip) begin
                flip_q <= wdata[0];
            end
            if (wr_ack) begin
                kclk_pull <= wdata[DATA_W-1];
            end
        end
    end

    assign flip_eff = flip_q & ~flip_disable;

    a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bank |=> (bank_en == $past(wdata[bank_bit_sel])));
    a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_bank |=> $stable(bank_en));
    a_r6_kclk_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> (kclk_pull == $past(wdata[DATA_W-1])));
    a_r4_jumper_off: assert property (@(posedge clk) disable iff (!rst_n)
        flip_disable |-> !flip_eff);
endmodule

// File: rtl/cpd_ready_fsm.sv
module cpd_ready_fsm
    import ctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ack,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] kbd_byte,
    input  logic              kbd_strobe,
    input  logic              pen_in,
    output logic              ready,
    output logic [DATA_W-1:0] data_q
);
    rdy_state_e state_q, state_d;
    logic       pen_q;
    logic       pen_rise;
    logic       load_key;

    assign pen_rise = pen_in & ~pen_q;

    always_comb begin
        state_d  = state_q;
        load_key = 1'b0;
        unique case (state_q)
            RS_EMPTY: begin
                if (wr_ack) begin
                    state_d = RS_EMPTY;
                end else if (wr_load) begin
                    state_d = RS_HOST;
                end else if (kbd_strobe) begin
                    state_d  = RS_KEY;
                    load_key = 1'b1;
                end else if (pen_rise) begin
                    state_d = RS_PEN;
                end
            end
            RS_KEY, RS_PEN, RS_HOST: begin
                if (wr_ack) begin
                    state_d = RS_EMPTY;
                end else if (wr_load) begin
                    state_d = RS_HOST;
                end
            end
            default: state_d = RS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_EMPTY;
            pen_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pen_q   <= pen_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_ack) begin
            data_q <= '0;
        end else if (load_key) begin
            data_q <= kbd_byte;
        end
    end

    assign ready = (state_q != RS_EMPTY);

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> (!ready && data_q == '0));
    a_r7_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && !wr_ack) |=> (state_q == RS_HOST));
    a_r8_key_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && kbd_strobe && !wr_ack && !wr_load) |=> (ready && data_q == $past(kbd_byte)));
    a_r9_held_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !wr_ack) |=> (ready && $stable(data_q)));
endmodule

// File: rtl/ctl_port_decoder.sv
module ctl_port_decoder
    import ctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int REL_W  = 4,
    localparam int TOP_W  = 4,
    localparam int BASE_W = ADDR_W - TOP_W - REL_W,
    localparam int NPORT  = 1 << REL_W,
    localparam int SEL_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [BASE_W-1:0] base_sel,
    input  logic [SEL_W-1:0]  bank_bit_sel,
    input  logic              flip_disable,
    input  logic [DATA_W-1:0] kbd_byte,
    input  logic              kbd_strobe,
    input  logic              pen_in,
    input  logic              pen_sw,
    input  logic              vsync,
    input  logic              disp_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [NPORT-1:0]  port_en,
    output logic              mem_access_en,
    output logic              mem_a15_flip,
    output logic              irq,
    output logic              kbd_clk_pull
);
    logic [REL_W-1:0]  rel;
    logic              rd_ok, wr_ok;
    logic              bank_en, flip_eff;
    logic              ready;
    logic [DATA_W-1:0] in_data;
    logic              wr_bank, wr_flip, wr_ack, wr_load;

    cpd_decode #(
        .ADDR_W (ADDR_W),
        .REL_W  (REL_W),
        .TOP_W  (TOP_W)
    ) u_decode (
        .io_addr  (io_addr),
        .base_sel (base_sel),
        .flip_eff (flip_eff),
        .bank_en  (bank_en),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .rel      (rel),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .port_en  (port_en)
    );

    assign wr_bank = wr_ok && (rel == P_BANK);
    assign wr_flip = wr_ok && (rel == P_FLIP);
    assign wr_ack  = wr_ok && (rel == P_ACK);
    assign wr_load = wr_ok && (rel == P_LOAD);

    cpd_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_bank      (wr_bank),
        .wr_flip      (wr_flip),
        .wr_ack       (wr_ack),
        .wdata        (io_wdata),
        .bank_bit_sel (bank_bit_sel),
        .flip_disable (flip_disable),
        .bank_en      (bank_en),
        .flip_eff     (flip_eff),
        .kclk_pull    (kbd_clk_pull)
    );

    cpd_ready_fsm #(
        .DATA_W (DATA_W)
    ) u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ack     (wr_ack),
        .wr_load    (wr_load),
        .kbd_byte   (kbd_byte),
        .kbd_strobe (kbd_strobe),
        .pen_in     (pen_in),
        .ready      (ready),
        .data_q     (in_data)
    );

    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            unique case (rel)
                P_STATUS: begin
                    rd_data      = '0;
                    rd_data[3:0] = {vsync, pen_sw, ready, disp_en};
                end
                P_LOAD:  rd_data = in_data;
                default: rd_data = '1;
            endcase
        end
    end

    assign rd_valid      = rd_ok;
    assign mem_access_en = bank_en;
    assign mem_a15_flip  = flip_eff;
    assign irq           = ready;

    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_access_en && io_addr[REL_W-1:0] != '0) |-> (port_en == '0 && !rd_valid));
    a_r10_no_stray_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));
    a_r1_top_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr[ADDR_W-1 -: TOP_W] != '0) |-> (port_en == '0));
endmodule

// File: tb/ctl_port_decoder_tb.sv
module ctl_port_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  base_sel = 8'h3D;
    logic [2:0]  bank_bit_sel = 3'd3;
    logic        flip_disable = 1'b0;
    logic [7:0]  kbd_byte = '0;
    logic        kbd_strobe = 1'b0, pen_in = 1'b0, pen_sw = 1'b0;
    logic        vsync = 1'b0, disp_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [15:0] port_en;
    logic        mem_access_en, mem_a15_flip, irq, kbd_clk_pull;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit       m_bank, m_flip, m_ready, m_kclk, m_pen_prev;
    bit [7:0] m_data;

    always #2 clk = ~clk;

    ctl_port_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .base_sel(base_sel),
        .bank_bit_sel(bank_bit_sel), .flip_disable(flip_disable),
        .kbd_byte(kbd_byte), .kbd_strobe(kbd_strobe), .pen_in(pen_in),
        .pen_sw(pen_sw), .vsync(vsync), .disp_en(disp_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .port_en(port_en),
        .mem_access_en(mem_access_en), .mem_a15_flip(mem_a15_flip),
        .irq(irq), .kbd_clk_pull(kbd_clk_pull)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_flip_eff();
        return m_flip && !flip_disable;
    endfunction

    function automatic bit [7:0] m_base();
        bit [7:0] b = base_sel;
        if (m_flip_eff()) b = b ^ 8'h06;
        return b;
    endfunction

    function automatic bit m_allowed();
        bit hit = (io_addr[15:12] == 4'h0) && (io_addr[11:4] == m_base());
        return hit && (m_bank || io_addr[3:0] == 4'd0);
    endfunction

    task automatic compare();
        bit       ok = m_allowed();
        bit       erd = io_rd && ok;
        int       rel = io_addr[3:0];
        bit [7:0] ed = 8'h00;
        bit [15:0] ep = 16'h0;
        string    rtag = "R10";
        if ((io_rd || io_wr) && ok) ep = 16'h1 << rel;
        if (erd) begin
            if (rel == 10) begin ed = {4'h0, vsync, pen_sw, m_ready, disp_en}; rtag = "R5"; end
            else if (rel == 12) begin ed = m_data; rtag = "R7"; end
            else ed = 8'hFF;
        end
        chk("R3", "rd_valid", rd_valid, erd);
        chk(rtag, "rd_data", rd_data, ed);
        chk("R11", "port_en", port_en, ep);
        chk("R8", "irq", irq, m_ready);
        chk("R6", "kbd_clk_pull", kbd_clk_pull, m_kclk);
        chk("R2", "mem_access_en", mem_access_en, m_bank);
        chk("R4", "mem_a15_flip", mem_a15_flip, m_flip_eff());
    endtask

    task automatic model_update();
        bit ok = m_allowed();
        int rel = io_addr[3:0];
        bit w11 = io_wr && ok && rel == 11;
        bit w12 = io_wr && ok && rel == 12;
        bit rise = pen_in && !m_pen_prev;
        if (io_wr && ok) begin
            if (rel == 0) m_bank = io_wdata[bank_bit_sel];
            if (rel == 1) m_flip = io_wdata[0];
            if (rel == 11) m_kclk = io_wdata[7];
        end
        if (w11) begin
            m_ready = 0; m_data = 8'h00;
        end else if (w12) begin
            m_ready = 1;
        end else if (!m_ready) begin
            if (kbd_strobe) begin m_data = kbd_byte; m_ready = 1; end
            else if (rise) m_ready = 1;
        end
        m_pen_prev = pen_in;
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    function automatic bit [15:0] pa(int rel);
        return {4'h0, m_base(), 4'(rel)};
    endfunction

    task automatic wr(int rel, bit [7:0] d);
        io_addr = pa(rel); io_wdata = d; io_wr = 1; step(); io_wr = 0;
    endtask

    task automatic rd(int rel);
        io_addr = pa(rel); io_rd = 1; step(); io_rd = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        m_bank = 1; m_flip = 0; m_ready = 0; m_kclk = 0; m_pen_prev = 0; m_data = 0;
        repeat (3) @(negedge clk);
        // reset values (R2, R4, R6, R8)
        chk("R2", "reset bank", mem_access_en, 1);
        chk("R4", "reset flip", mem_a15_flip, 0);
        chk("R6", "reset kclk", kbd_clk_pull, 0);
        chk("R8", "reset irq", irq, 0);
        rst_n = 1;
        idle(2);
        // R5 status with varied raw inputs
        vsync = 1; disp_en = 1; rd(10);
        vsync = 0; pen_sw = 1; disp_en = 0; rd(10);
        // R10 unused ports and stray writes
        rd(3); wr(3, 8'h00); rd(15); rd(0); rd(11);
        // R1 wrong top nibble and wrong base
        io_addr = 16'h13DA; io_rd = 1; step(); io_rd = 0;
        io_addr = 16'h03EA; io_rd = 1; step(); io_rd = 0;
        // R8 keyboard capture, R7 read-back
        kbd_byte = 8'h5A; kbd_strobe = 1; step(); kbd_strobe = 0;
        rd(12); rd(10);
        // R9 events ignored while held
        kbd_byte = 8'h33; kbd_strobe = 1; step(); kbd_strobe = 0;
        pen_in = 1; step(); pen_in = 0; step();
        rd(12);
        // R6 acknowledge with clock hold
        wr(11, 8'h80); rd(12); rd(10);
        // R8 pen edge
        pen_in = 1; idle(2); pen_in = 0; rd(12);
        wr(11, 8'h00);
        // R9 port write wins over same-cycle key
        kbd_byte = 8'hA5; kbd_strobe = 1; wr(12, 8'h00); kbd_strobe = 0;
        rd(12);
        kbd_byte = 8'hC3; kbd_strobe = 1; wr(11, 8'h00); kbd_strobe = 0;
        rd(12);
        // R4 relocation
        wr(1, 8'h01);
        io_addr = 16'h03DA; io_rd = 1; step(); io_rd = 0;
        rd(10);
        flip_disable = 1; rd(10);
        io_addr = 16'h03BA; io_rd = 1; step(); io_rd = 0;
        flip_disable = 0; wr(1, 8'hFE); rd(10);
        // R2/R3 bank disable and recovery
        wr(0, 8'hF7);
        rd(10); wr(12, 8'h00); rd(12); wr(1, 8'h01); wr(11, 8'h80);
        kbd_byte = 8'h44; kbd_strobe = 1; step(); kbd_strobe = 0;
        rd(0);
        bank_bit_sel = 3'd5; wr(0, 8'h20); rd(12);
        wr(11, 8'h00);
        idle(3);
        finish_run();
    end
endmodule